// File: doc/BRIEF.md
# Extended-State Save Planning Unit

This block prepares a supervisor-level save of extended processor state for a small CPU model. When `start` is pulsed it works out which state components must be written to the save area. The request comes from a 64-bit mask held in a register pair. That mask is trimmed by the union of the user-enabled and supervisor-enabled component sets. The result is further filtered by the components that are in use and by whether the save may be skipped. The block also produces the two header words that the memory side writes into the save area, and a flag that reports whether the skip optimisation was allowed.

A save may skip a component only when two things hold. First, the current context tuple must equal the tuple recorded by the most recent restore. The tuple holds the privilege level, the guest flag, the save-area linear address and the compaction mask. Second, the component must be unmodified since that restore. The restore side records its tuple through a separate snapshot write port. Component 1 holds the SIMD control/status word, and it is saved even when it is not in use if that word differs from its power-on value.

After planning, the block sends one save request per selected component over a valid/ready port, in ascending index order, and then pulses `done`. The controller has three states:
- `ST_IDLE` waits for `start`. Start with nothing to save goes to `ST_FINAL`. Start with work goes to `ST_ISSUE`.
- `ST_ISSUE` presents the lowest pending index. It moves on when `req_ready` accepts the request. If more requests remain it stays in `ST_ISSUE`; once none remain it goes to `ST_FINAL`.
- `ST_FINAL` raises `done` for one cycle and always returns to `ST_IDLE`.

Top module: `ext_state_save_planner`

## Requirements
- R1: The feature mask is the 64-bit request `{req_hi[31:0], req_lo[31:0]}` ANDed with `en_user | en_sup`.
- R2: Bits 63:32 of both `req_hi` and `req_lo` have no effect on any output.
- R3: `hdr_comp` equals the feature mask with bit 63 forced to 1.
- R4: `hdr_state` equals `inuse` ANDed with the feature mask.
- R5: Component i (for i other than 1) is a save candidate exactly when feature bit i and `inuse[i]` are both 1.
- R6: Component 1 is also a candidate, provided feature bit 1 is set, when `inuse[1]` is 0 and `sse_ctl` is not 32'h1F80.
- R7: `opt_ok` is 1 only when a valid snapshot equals `{priv, guest, area_addr, hdr_comp}` in every field.
- R8: A candidate is left out of `save_vec` only when `opt_ok` is 1 and its `dirty` bit is 0.
- R9: One request is outstanding at a time. Requests follow ascending index order. `req_valid` and `req_idx` hold until `req_ready`. `start` while busy is ignored.
- R10: `done` is a one-cycle pulse. It rises in the cycle after the last request is accepted, or in the cycle after `start` when `save_vec` is 0.
- R11: A snapshot is loaded by `snap_wr`. A snapshot written with `snap_valid` = 0 never matches.
- R12: `hdr_state` and `save_vec` carry nothing at or above index NCOMP (8), although `hdr_comp` keeps those request bits.
- R13: `save_vec`, `hdr_state`, `hdr_comp` and `opt_ok` are captured at `start` and hold while the requests run, even if the inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin planning (accepted only when idle) |
| req_hi | input | 64 | Upper request register; bits 31:0 used |
| req_lo | input | 64 | Lower request register; bits 31:0 used |
| en_user | input | 64 | User-enabled components |
| en_sup | input | 64 | Supervisor-enabled components |
| inuse | input | NCOMP | Component in-use bitmap |
| dirty | input | NCOMP | Modified since last restore |
| sse_ctl | input | 32 | SIMD control/status word |
| priv | input | 2 | Current privilege level |
| guest | input | 1 | Running as virtualised guest |
| area_addr | input | 64 | Save-area linear address |
| snap_wr | input | 1 | Load the restore snapshot |
| snap_valid | input | 1 | Snapshot valid bit to load |
| snap_priv | input | 2 | Snapshot privilege level |
| snap_guest | input | 1 | Snapshot guest flag |
| snap_addr | input | 64 | Snapshot linear address |
| snap_mask | input | 64 | Snapshot compaction mask |
| req_ready | input | 1 | Memory side accepts the request |
| req_valid | output | 1 | Save request present |
| req_idx | output | 3 | Component index of the request |
| done | output | 1 | One-cycle completion pulse |
| save_vec | output | NCOMP | Components selected for saving |
| hdr_state | output | 64 | First header word |
| hdr_comp | output | 64 | Second header word (compaction mask) |
| opt_ok | output | 1 | Skip optimisation permitted |

## Verification
The skip path is the hardest case to reach from the ports. It needs a valid snapshot that matches the current tuple in all four fields, including a 64-bit compaction mask that depends on the request and on both enable registers. The sweep therefore computes the expected mask in the bench first. It then writes that exact tuple through the snapshot port, or a copy with one chosen field perturbed, or an invalid copy, or leaves an older snapshot in place. The in-use, modified and control-word patterns vary across 256 runs, so every component meets skipping, forced saving and plain saving.

// File: rtl/essp_pkg.sv
package essp_pkg;
    localparam int WORD_W = 64;
    localparam int HALF_W = WORD_W / 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_FINAL = 2'd2
    } plan_state_e;
endpackage

// File: rtl/essp_filter.sv
module essp_filter
    import essp_pkg::*;
#(
    parameter int NCOMP = 8,
    parameter int SSE_IDX = 1,
    parameter int CTL_W = 32,
    parameter logic [CTL_W-1:0] CTL_RST = 32'h0000_1F80
) (
    input  logic [WORD_W-1:0] req_hi,
    input  logic [WORD_W-1:0] req_lo,
    input  logic [WORD_W-1:0] en_user,
    input  logic [WORD_W-1:0] en_sup,
    input  logic [NCOMP-1:0]  inuse,
    input  logic [CTL_W-1:0]  sse_ctl,
    output logic [WORD_W-1:0] feat,
    output logic [WORD_W-1:0] comp_mask,
    output logic [WORD_W-1:0] hdr_first,
    output logic [NCOMP-1:0]  cand
);
    logic [WORD_W-1:0] req_full;
    logic              ctl_moved;

    assign req_full  = {req_hi[HALF_W-1:0], req_lo[HALF_W-1:0]};
    assign feat      = req_full & (en_user | en_sup);
    assign comp_mask = {1'b1, feat[WORD_W-2:0]};
    assign hdr_first = {{(WORD_W-NCOMP){1'b0}}, inuse & feat[NCOMP-1:0]};
    assign ctl_moved = (sse_ctl != CTL_RST);

    for (genvar i = 0; i < NCOMP; i++) begin : g_cand
        if (i == SSE_IDX) begin : g_simd
            assign cand[i] = feat[i] & (inuse[i] | ctl_moved);
        end else begin : g_plain
            assign cand[i] = feat[i] & inuse[i];
        end
    end
endmodule

// File: rtl/essp_snapshot.sv
module essp_snapshot
    import essp_pkg::*;
#(
    parameter int PRIV_W = 2,
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              wr_valid,
    input  logic [PRIV_W-1:0] wr_priv,
    input  logic              wr_guest,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_mask,
    input  logic [PRIV_W-1:0] cur_priv,
    input  logic              cur_guest,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [WORD_W-1:0] cur_mask,
    output logic              live,
    output logic              match
);
    logic              valid_q;
    logic [PRIV_W-1:0] priv_q;
    logic              guest_q;
    logic [ADDR_W-1:0] addr_q;
    logic [WORD_W-1:0] mask_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            priv_q  <= '0;
            guest_q <= 1'b0;
            addr_q  <= '0;
            mask_q  <= '0;
        end else if (wr) begin
            valid_q <= wr_valid;
            priv_q  <= wr_priv;
            guest_q <= wr_guest;
            addr_q  <= wr_addr;
            mask_q  <= wr_mask;
        end
    end

    assign live  = valid_q;
    assign match = valid_q
                 && (priv_q  == cur_priv)
                 && (guest_q == cur_guest)
                 && (addr_q  == cur_addr)
                 && (mask_q  == cur_mask);
endmodule

// File: rtl/essp_pick.sv
module essp_pick #(
    parameter int NCOMP = 8,
    localparam int IDX_W = $clog2(NCOMP)
) (
    input  logic [NCOMP-1:0] pend,
    output logic [IDX_W-1:0] idx,
    output logic [NCOMP-1:0] idx_onehot
);
    always_comb begin
        idx = '0;
        for (int i = NCOMP - 1; i >= 0; i--) begin
            if (pend[i]) idx = IDX_W'(i);
        end
    end

    assign idx_onehot = pend & ~(pend - NCOMP'(1));
endmodule

// File: rtl/ext_state_save_planner.sv
module ext_state_save_planner
    import essp_pkg::*;
#(
    parameter int NCOMP = 8,
    parameter int PRIV_W = 2,
    parameter int ADDR_W = 64,
    parameter int CTL_W = 32,
    localparam int IDX_W = $clog2(NCOMP)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [63:0]       req_hi,
    input  logic [63:0]       req_lo,
    input  logic [63:0]       en_user,
    input  logic [63:0]       en_sup,
    input  logic [NCOMP-1:0]  inuse,
    input  logic [NCOMP-1:0]  dirty,
    input  logic [CTL_W-1:0]  sse_ctl,
    input  logic [PRIV_W-1:0] priv,
    input  logic              guest,
    input  logic [ADDR_W-1:0] area_addr,
    input  logic              snap_wr,
    input  logic              snap_valid,
    input  logic [PRIV_W-1:0] snap_priv,
    input  logic              snap_guest,
    input  logic [ADDR_W-1:0] snap_addr,
    input  logic [63:0]       snap_mask,
    input  logic              req_ready,
    output logic              req_valid,
    output logic [IDX_W-1:0]  req_idx,
    output logic              done,
    output logic [NCOMP-1:0]  save_vec,
    output logic [63:0]       hdr_state,
    output logic [63:0]       hdr_comp,
    output logic              opt_ok
);
    plan_state_e       state_q, state_nx;
    logic [NCOMP-1:0]  pend_q, pend_nx;
    logic [NCOMP-1:0]  vec_q;
    logic [63:0]       first_q, comp_q;
    logic              opt_q;

    logic [63:0]       feat, comp_mask, hdr_first;
    logic [NCOMP-1:0]  cand, plan_vec, pick_oh;
    logic [IDX_W-1:0]  pick_idx;
    logic              snap_match, snap_live;
    logic              accept, take_start;

    essp_filter #(.NCOMP(NCOMP), .CTL_W(CTL_W)) u_filter (
        .req_hi    (req_hi),
        .req_lo    (req_lo),
        .en_user   (en_user),
        .en_sup    (en_sup),
        .inuse     (inuse),
        .sse_ctl   (sse_ctl),
        .feat      (feat),
        .comp_mask (comp_mask),
        .hdr_first (hdr_first),
        .cand      (cand)
    );

    essp_snapshot #(.PRIV_W(PRIV_W), .ADDR_W(ADDR_W)) u_snap (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (snap_wr),
        .wr_valid  (snap_valid),
        .wr_priv   (snap_priv),
        .wr_guest  (snap_guest),
        .wr_addr   (snap_addr),
        .wr_mask   (snap_mask),
        .cur_priv  (priv),
        .cur_guest (guest),
        .cur_addr  (area_addr),
        .cur_mask  (comp_mask),
        .live      (snap_live),
        .match     (snap_match)
    );

    essp_pick #(.NCOMP(NCOMP)) u_pick (
        .pend       (pend_q),
        .idx        (pick_idx),
        .idx_onehot (pick_oh)
    );

    // A candidate drops out only when the context matches and it is clean
    assign plan_vec   = cand & ~({NCOMP{snap_match}} & ~dirty);
    assign take_start = (state_q == ST_IDLE) && start;
    assign accept     = (state_q == ST_ISSUE) && req_ready;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pend_q  <= '0;
            vec_q   <= '0;
            first_q <= '0;
            comp_q  <= '0;
            opt_q   <= 1'b0;
        end else begin
            state_q <= state_nx;
            pend_q  <= pend_nx;
            if (take_start) begin
                vec_q   <= plan_vec;
                first_q <= hdr_first;
                comp_q  <= comp_mask;
                opt_q   <= snap_match;
            end
        end
    end

    // Next state
    always_comb begin
        state_nx = state_q;
        pend_nx  = pend_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    pend_nx  = plan_vec;
                    state_nx = (plan_vec == '0) ? ST_FINAL : ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                if (accept) begin
                    pend_nx  = pend_q & ~pick_oh;
                    state_nx = ((pend_q & ~pick_oh) == '0) ? ST_FINAL : ST_ISSUE;
                end
            end
            ST_FINAL: begin
                state_nx = ST_IDLE;
            end
            default: begin
                state_nx = ST_IDLE;
                pend_nx  = '0;
            end
        endcase
    end

    // Outputs
    always_comb begin
        req_valid = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_ISSUE: req_valid = 1'b1;
            ST_FINAL: done = 1'b1;
            default:  ;
        endcase
    end

    assign req_idx   = pick_idx;
    assign save_vec  = vec_q;
    assign hdr_state = first_q;
    assign hdr_comp  = comp_q;
    assign opt_ok    = opt_q;
endmodule

// File: rtl/essp_checks.sv
module essp_checks #(
    parameter int NCOMP = 8,
    localparam int IDX_W = $clog2(NCOMP)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             req_ready,
    input logic             req_valid,
    input logic [IDX_W-1:0] req_idx,
    input logic             done,
    input logic [NCOMP-1:0] save_vec,
    input logic [63:0]      hdr_state,
    input logic [63:0]      hdr_comp,
    input logic             opt_ok,
    input logic             snap_live
);
    p_comp_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> hdr_comp[63]);

    p_first_sub_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((hdr_state & ~hdr_comp) == 64'd0));

    p_vec_in_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((save_vec & ~hdr_comp[NCOMP-1:0]) == '0));

    p_upper_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((hdr_state >> NCOMP) == 64'd0));

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_idx)));

    p_planned_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> save_vec[req_idx]);

    p_ascend_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!req_valid || (req_idx > $past(req_idx))));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && req_valid));

    p_invalid_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !snap_live && !req_valid && !done) |=> !opt_ok);

    p_plan_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> ($stable(save_vec) && $stable(hdr_comp) && $stable(opt_ok)));
endmodule

bind ext_state_save_planner essp_checks #(.NCOMP(NCOMP)) u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .req_ready (req_ready),
    .req_valid (req_valid),
    .req_idx   (req_idx),
    .done      (done),
    .save_vec  (save_vec),
    .hdr_state (hdr_state),
    .hdr_comp  (hdr_comp),
    .opt_ok    (opt_ok),
    .snap_live (snap_live)
);

// File: tb/sim_ext_state_save_planner.sv
module sim_ext_state_save_planner;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [63:0] req_hi = '0, req_lo = '0, en_user = '0, en_sup = '0;
    logic [7:0]  inuse = '0, dirty = '0;
    logic [31:0] sse_ctl = 32'h1F80;
    logic [1:0]  priv = '0;
    logic        guest = 1'b0;
    logic [63:0] area_addr = '0;
    logic        snap_wr = 1'b0, snap_valid = 1'b0, snap_guest = 1'b0;
    logic [1:0]  snap_priv = '0;
    logic [63:0] snap_addr = '0, snap_mask = '0;
    logic        req_ready = 1'b0;
    logic        req_valid, done, opt_ok;
    logic [2:0]  req_idx;
    logic [7:0]  save_vec;
    logic [63:0] hdr_state, hdr_comp;

    int n_chk = 0;
    int n_bad = 0;

    // bench model of the snapshot register
    logic        m_v = 1'b0, m_g = 1'b0;
    logic [1:0]  m_p = '0;
    logic [63:0] m_a = '0, m_m = '0;

    logic [63:0] e_feat, e_comp, e_first;
    logic [7:0]  e_cand, e_vec;
    logic        e_opt;

    always #2.5 clk = ~clk;

    ext_state_save_planner u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .req_hi(req_hi), .req_lo(req_lo), .en_user(en_user), .en_sup(en_sup),
        .inuse(inuse), .dirty(dirty), .sse_ctl(sse_ctl),
        .priv(priv), .guest(guest), .area_addr(area_addr),
        .snap_wr(snap_wr), .snap_valid(snap_valid), .snap_priv(snap_priv),
        .snap_guest(snap_guest), .snap_addr(snap_addr), .snap_mask(snap_mask),
        .req_ready(req_ready), .req_valid(req_valid), .req_idx(req_idx),
        .done(done), .save_vec(save_vec), .hdr_state(hdr_state),
        .hdr_comp(hdr_comp), .opt_ok(opt_ok)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic load_snap(input logic v, input logic [1:0] p, input logic g,
                             input logic [63:0] a, input logic [63:0] m);
        snap_wr = 1'b1; snap_valid = v; snap_priv = p; snap_guest = g;
        snap_addr = a; snap_mask = m;
        @(negedge clk);
        snap_wr = 1'b0;
        m_v = v; m_p = p; m_g = g; m_a = a; m_m = m;
    endtask

    task automatic model();
        e_feat  = {req_hi[31:0], req_lo[31:0]} & (en_user | en_sup);
        e_comp  = e_feat | (64'd1 << 63);
        e_first = {56'd0, inuse & e_feat[7:0]};
        for (int i = 0; i < 8; i++)
            e_cand[i] = e_feat[i] & (inuse[i] | ((i == 1) && (sse_ctl != 32'h1F80)));
        e_opt = m_v && (m_p == priv) && (m_g == guest) && (m_a == area_addr) && (m_m == e_comp);
        e_vec = e_opt ? (e_cand & dirty) : e_cand;
    endtask

    task automatic run(input int n);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(hdr_comp == e_comp, "R1 R2 R3 header word two", hdr_comp, e_comp);
        chk(hdr_state == e_first, "R4 R12 header word one", hdr_state, e_first);
        chk(opt_ok == e_opt, "R7 R11 skip permission", {63'd0, opt_ok}, {63'd0, e_opt});
        chk(save_vec == e_vec, "R5 R6 R8 save vector", {56'd0, save_vec}, {56'd0, e_vec});
        // disturb the inputs: the captured plan must not move (R13)
        inuse = ~inuse; dirty = ~dirty; req_lo = ~req_lo; sse_ctl = ~sse_ctl;
        for (int i = 0; i < 8; i++) begin
            if (e_vec[i]) begin
                for (int k = 0; k < (n + i) % 3; k++) begin
                    chk(req_valid && req_idx == 3'(i), "R9 request held",
                        {60'd0, req_valid, req_idx}, {60'd0, 1'b1, 3'(i)});
                    if (n % 7 == 0 && k == 0) start = 1'b1;
                    @(negedge clk);
                    start = 1'b0;
                end
                chk(req_valid && req_idx == 3'(i), "R9 request order",
                    {60'd0, req_valid, req_idx}, {60'd0, 1'b1, 3'(i)});
                req_ready = 1'b1;
                @(negedge clk);
                req_ready = 1'b0;
            end
        end
        chk(done && !req_valid, "R10 done after last", {62'd0, done, req_valid}, 64'd2);
        chk(save_vec == e_vec && hdr_state == e_first && hdr_comp == e_comp,
            "R13 plan held", {56'd0, save_vec}, {56'd0, e_vec});
        @(negedge clk);
        chk(!done && !req_valid, "R10 done is one pulse", {62'd0, done, req_valid}, 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!req_valid && !done && save_vec == '0 && hdr_comp == '0 && !opt_ok,
            "R10 reset state", {62'd0, req_valid, done}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int n = 0; n < 256; n++) begin
            logic [7:0] nb;
            nb = 8'(n);
            inuse   = nb;
            dirty   = {nb[2:0], nb[7:3]} ^ 8'h5A;
            req_lo  = {~{nb, nb, nb, nb}, 16'hA5C3, 8'(n * 3), 8'(n * 5 + 3)};
            req_hi  = {32'hFFFF_FFFF, 32'h8000_1234 ^ {nb, 24'd0}};
            en_user = nb[0] ? 64'h0000_0000_0000_00F5 : 64'h0000_0000_0000_0035;
            en_sup  = 64'h8000_0100_0000_000A;
            sse_ctl = (n % 3 == 0) ? 32'h1F80 : (32'h1F80 ^ (32'd1 << (n % 16)));
            priv    = nb[3:2];
            guest   = nb[4];
            area_addr = 64'h1000 + 64'(n) * 64;
            model();
            case (n % 4)
                0: load_snap(1'b1, priv, guest, area_addr, e_comp);
                1: case ((n / 4) % 4)
                       0: load_snap(1'b1, priv ^ 2'd1, guest, area_addr, e_comp);
                       1: load_snap(1'b1, priv, ~guest, area_addr, e_comp);
                       2: load_snap(1'b1, priv, guest, area_addr ^ 64'h40, e_comp);
                       default: load_snap(1'b1, priv, guest, area_addr, e_comp ^ 64'h20);
                   endcase
                2: load_snap(1'b0, priv, guest, area_addr, e_comp);
                default: ;
            endcase
            model();
            run(n);
        end
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule